// File: doc/BRIEF.md
# Host Bridge Configuration Register File

This block holds the 256-byte type-0 PCI configuration space of a host bridge. A single byte-wide port carries an 8-bit offset, write data, a write strobe and combinational read data. Each write passes through a per-offset rule before it is stored. The rule can do one of four things: keep only the writable bits and add forced-one bits, clear status bits where a one is written, accept the write only while an unlock bit is set, or drop the write.

On reset every byte takes a fixed default value. A few stored bytes drive other logic directly. These are two cache enables, the memory-hole/routing byte, the system-management RAM control byte, and the two 16-bit shadow enable vectors for reads and writes. The bus transaction layer, the DRAM row decode and any side effects of these bytes lie outside the block.

Top module: `hb_cfg_regfile`

## Requirements
- R1: With `rst` high at a clock edge, every byte takes its default. 00h..03h and 2Ch..2Fh hold B9h, 10h, 31h, 15h in that order. 04h=06h, 07h=04h, 08h=B0h, 0Bh=06h, 0Dh=20h, 52h=F0h, 54h=FFh, 55h=FFh, 59h=20h, 5Ah=20h and 70h=22h. Even offsets 60h..6Eh hold 08h and odd offsets 61h..6Fh hold 40h. Every other byte is 00h.
- R2: `cfg_rdata` is the byte stored at `cfg_addr` at any offset. A write commits at the rising edge where `cfg_we` is high. A read in that same cycle shows the value from before the write.
- R3: These offsets store the written byte unchanged: 04h, 43h..48h, 4Ah, 4Ch..4Fh, 50h..52h, 54h..56h, 59h, 5Ah, 5Ch, 60h..6Fh, 70h, 71h, 76h and 77h.
- R4: These offsets store the write data ANDed with a mask, so bits outside the mask read 0: 05h:01h, 0Dh:F8h, 40h:F1h, 42h:F7h, 49h:73h, 57h:60h, 58h:86h, 5Bh:4Fh, 5Dh:53h, 5Fh:7Fh, 72h:0Fh, 74h:2Bh, 80h:84h, 81h:81h, 83h:10h.
- R5: A write to 41h stores (data AND D6h) OR 08h, so bit 3 reads 1 after any write to it.
- R6: At offset 07h, writing a 1 to any of bits 7:3 clears that bit, and bits 2:0 keep their value. The byte therefore stays 04h after any write.
- R7: Offsets 2Ch..2Fh store the full written byte only while bit 3 of offset 70h is 1. Otherwise the write is dropped.
- R8: A write to any offset not named in R3..R7 leaves the stored byte unchanged.
- R9: `ext_cache_en` equals bit 0 of 42h and `int_cache_en` equals bit 0 of 43h. Both follow a write from the edge that commits it.
- R10: `mem_route` equals byte 47h and `smram_ctl` equals byte 48h. `shadow_rd_en` is {4Dh,4Ch} and `shadow_wr_en` is {4Fh,4Eh}, with the higher offset in the upper byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Write strobe |
| cfg_rdata | output | 8 | Stored byte at `cfg_addr` |
| ext_cache_en | output | 1 | External cache enable |
| int_cache_en | output | 1 | Internal cache enable |
| mem_route | output | 8 | Memory routing control byte |
| smram_ctl | output | 8 | System-management RAM control byte |
| shadow_rd_en | output | 16 | Shadow read enables, one per 16 KiB segment |
| shadow_wr_en | output | 16 | Shadow write enables, one per 16 KiB segment |

## Verification
A read and a write to the same offset can fall in the same cycle, because both share `cfg_addr`. Every write in the bench is made that way. `cfg_rdata` is sampled after the inputs settle but before the committing edge, and it must equal the model's pre-write byte. The offset is read again after the edge and must show the rule-applied value. The lock and its unlock bit also interact across back-to-back writes. The bench flips 70h bit 3 and writes 2Ch..2Fh in the next cycle to confirm that the lock takes effect at once.

// File: rtl/hb_cfg_pkg.sv
package hb_cfg_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    localparam logic [ADDR_W-1:0] OFS_LOCK_CTL = 8'h70;
    localparam int                LOCK_BIT     = 3;

    typedef enum logic [1:0] {
        WK_DROP   = 2'd0,
        WK_MASKED = 2'd1,
        WK_CLR1   = 2'd2,
        WK_GUARD  = 2'd3
    } wkind_e;

    typedef struct packed {
        wkind_e            kind;
        logic [DATA_W-1:0] keep;
        logic [DATA_W-1:0] setb;
    } wrule_t;

    function automatic wrule_t mk(input wkind_e k, input logic [7:0] m, input logic [7:0] s);
        wrule_t r;
        r.kind = k;
        r.keep = m;
        r.setb = s;
        return r;
    endfunction

    function automatic wrule_t rule_of(input logic [ADDR_W-1:0] a);
        wrule_t r;
        case (a) inside
            8'h04, [8'h43:8'h48], 8'h4A, [8'h4C:8'h52], [8'h54:8'h56],
            8'h59, 8'h5A, 8'h5C, [8'h60:8'h71], 8'h76, 8'h77:
                      r = mk(WK_MASKED, 8'hFF, 8'h00);
            8'h05:    r = mk(WK_MASKED, 8'h01, 8'h00);
            8'h0D:    r = mk(WK_MASKED, 8'hF8, 8'h00);
            8'h40:    r = mk(WK_MASKED, 8'hF1, 8'h00);
            8'h41:    r = mk(WK_MASKED, 8'hD6, 8'h08);
            8'h42:    r = mk(WK_MASKED, 8'hF7, 8'h00);
            8'h49:    r = mk(WK_MASKED, 8'h73, 8'h00);
            8'h57:    r = mk(WK_MASKED, 8'h60, 8'h00);
            8'h58:    r = mk(WK_MASKED, 8'h86, 8'h00);
            8'h5B:    r = mk(WK_MASKED, 8'h4F, 8'h00);
            8'h5D:    r = mk(WK_MASKED, 8'h53, 8'h00);
            8'h5F:    r = mk(WK_MASKED, 8'h7F, 8'h00);
            8'h72:    r = mk(WK_MASKED, 8'h0F, 8'h00);
            8'h74:    r = mk(WK_MASKED, 8'h2B, 8'h00);
            8'h80:    r = mk(WK_MASKED, 8'h84, 8'h00);
            8'h81:    r = mk(WK_MASKED, 8'h81, 8'h00);
            8'h83:    r = mk(WK_MASKED, 8'h10, 8'h00);
            8'h07:    r = mk(WK_CLR1,   8'hF8, 8'h00);
            [8'h2C:8'h2F]:
                      r = mk(WK_GUARD,  8'hFF, 8'h00);
            default:  r = mk(WK_DROP,   8'h00, 8'h00);
        endcase
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] id_byte(input logic [1:0] i);
        case (i)
            2'd0:    return 8'hB9;
            2'd1:    return 8'h10;
            2'd2:    return 8'h31;
            default: return 8'h15;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] default_of(input logic [ADDR_W-1:0] a);
        if (a <= 8'h03 || (a >= 8'h2C && a <= 8'h2F)) return id_byte(a[1:0]);
        if (a >= 8'h60 && a <= 8'h6F)                 return a[0] ? 8'h40 : 8'h08;
        case (a)
            8'h04, 8'h0B: return 8'h06;
            8'h07:        return 8'h04;
            8'h08:        return 8'hB0;
            8'h0D, 8'h59, 8'h5A: return 8'h20;
            8'h52:        return 8'hF0;
            8'h54, 8'h55: return 8'hFF;
            8'h70:        return 8'h22;
            default:      return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/hb_cfg_rule_dec.sv
module hb_cfg_rule_dec
    import hb_cfg_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output wrule_t        rule
);
    always_comb rule = rule_of(addr);
endmodule

// File: rtl/hb_cfg_merge.sv
module hb_cfg_merge
    import hb_cfg_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  wrule_t        rule,
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] wdata,
    input  logic          unlocked,
    output logic [DW-1:0] nxt
);
    always_comb begin
        unique case (rule.kind)
            WK_MASKED: nxt = (wdata & rule.keep) | rule.setb;
            WK_CLR1:   nxt = cur & ~(wdata & rule.keep);
            WK_GUARD:  nxt = unlocked ? wdata : cur;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/hb_cfg_store.sv
module hb_cfg_store
    import hb_cfg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    localparam int NB = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] nxt,
    output logic [DW-1:0] bytes_q [NB]
);
    for (genvar i = 0; i < NB; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                bytes_q[i] <= default_of(AW'(i));
            else if (we && addr == AW'(i))
                bytes_q[i] <= nxt;
        end
    end
endmodule

// File: rtl/hb_cfg_export.sv
module hb_cfg_export
    import hb_cfg_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int NB = DEPTH
) (
    input  logic [DW-1:0]   bytes_q [NB],
    output logic            ext_cache_en,
    output logic            int_cache_en,
    output logic [DW-1:0]   mem_route,
    output logic [DW-1:0]   smram_ctl,
    output logic [2*DW-1:0] shadow_rd_en,
    output logic [2*DW-1:0] shadow_wr_en
);
    always_comb begin
        ext_cache_en = bytes_q[8'h42][0];
        int_cache_en = bytes_q[8'h43][0];
        mem_route    = bytes_q[8'h47];
        smram_ctl    = bytes_q[8'h48];
        shadow_rd_en = {bytes_q[8'h4D], bytes_q[8'h4C]};
        shadow_wr_en = {bytes_q[8'h4F], bytes_q[8'h4E]};
    end
endmodule

// File: rtl/hb_cfg_regfile.sv
module hb_cfg_regfile
    import hb_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    input  logic        cfg_we,
    output logic [7:0]  cfg_rdata,
    output logic        ext_cache_en,
    output logic        int_cache_en,
    output logic [7:0]  mem_route,
    output logic [7:0]  smram_ctl,
    output logic [15:0] shadow_rd_en,
    output logic [15:0] shadow_wr_en
);
    wrule_t            rule;
    logic [DATA_W-1:0] nxt;
    logic [DATA_W-1:0] regs [DEPTH];
    logic              unlocked;

    assign cfg_rdata = regs[cfg_addr];
    assign unlocked  = regs[OFS_LOCK_CTL][LOCK_BIT];

    hb_cfg_rule_dec #(.AW(ADDR_W)) u_dec (
        .addr (cfg_addr),
        .rule (rule)
    );

    hb_cfg_merge #(.DW(DATA_W)) u_merge (
        .rule     (rule),
        .cur      (cfg_rdata),
        .wdata    (cfg_wdata),
        .unlocked (unlocked),
        .nxt      (nxt)
    );

    hb_cfg_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .nxt     (nxt),
        .bytes_q (regs)
    );

    hb_cfg_export #(.DW(DATA_W)) u_exp (
        .bytes_q      (regs),
        .ext_cache_en (ext_cache_en),
        .int_cache_en (int_cache_en),
        .mem_route    (mem_route),
        .smram_ctl    (smram_ctl),
        .shadow_rd_en (shadow_rd_en),
        .shadow_wr_en (shadow_wr_en)
    );

    // R9: cache enable follows the committed write at 42h
    a_r9_ext_cache_follow: assert property (@(posedge clk) disable iff (rst)
        cfg_we && cfg_addr == 8'h42 |=> ext_cache_en == $past(cfg_wdata[0]));

    // R5: bit 3 of 41h is 1 after any write to it
    a_r5_forced_one: assert property (@(posedge clk) disable iff (rst)
        cfg_we && cfg_addr == 8'h41 |=> regs[8'h41][3]);

    // R7: a write to 2Ch..2Fh while locked leaves them unchanged
    a_r7_locked_hold: assert property (@(posedge clk) disable iff (rst)
        cfg_we && cfg_addr >= 8'h2C && cfg_addr <= 8'h2F && !unlocked
        |=> $stable(regs[8'h2C]) && $stable(regs[8'h2D])
            && $stable(regs[8'h2E]) && $stable(regs[8'h2F]));

    // R8: identification bytes never change after reset
    a_r8_id_hold: assert property (@(posedge clk) disable iff (rst)
        $stable(regs[8'h00]) && $stable(regs[8'h03]));

    // R6: status byte stays at its default under write-one-to-clear
    a_r6_status_low: assert property (@(posedge clk) disable iff (rst)
        cfg_we && cfg_addr == 8'h07 |=> regs[8'h07] == 8'h04);

endmodule

// File: tb/hb_cfg_regfile_tb_top.sv
module hb_cfg_regfile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_rdata;
    logic        ext_cache_en, int_cache_en;
    logic [7:0]  mem_route, smram_ctl;
    logic [15:0] shadow_rd_en, shadow_wr_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] model [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    hb_cfg_regfile dut_i (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .ext_cache_en(ext_cache_en),
        .int_cache_en(int_cache_en), .mem_route(mem_route), .smram_ctl(smram_ctl),
        .shadow_rd_en(shadow_rd_en), .shadow_wr_en(shadow_wr_en)
    );

    function automatic logic [7:0] exp_reset(input int a);
        logic [7:0] ids [4] = '{8'hB9, 8'h10, 8'h31, 8'h15};
        if (a < 4) return ids[a];
        if (a >= 'h2C && a < 'h30) return ids[a - 'h2C];
        if (a >= 'h60 && a < 'h70) return (a % 2 == 1) ? 8'h40 : 8'h08;
        if (a == 'h04 || a == 'h0B) return 8'h06;
        if (a == 'h07) return 8'h04;
        if (a == 'h08) return 8'hB0;
        if (a == 'h0D || a == 'h59 || a == 'h5A) return 8'h20;
        if (a == 'h52) return 8'hF0;
        if (a == 'h54 || a == 'h55) return 8'hFF;
        if (a == 'h70) return 8'h22;
        return 8'h00;
    endfunction

    // mask for plain stores; returns 0 with ok=0 for offsets without a plain rule
    function automatic logic [7:0] exp_mask(input int a, output bit ok);
        ok = 1'b1;
        if (a == 'h04 || a == 'h4A || a == 'h59 || a == 'h5A || a == 'h5C ||
            a == 'h70 || a == 'h71 || a == 'h76 || a == 'h77 ||
            (a >= 'h43 && a <= 'h48) || (a >= 'h4C && a <= 'h52) ||
            (a >= 'h54 && a <= 'h56) || (a >= 'h60 && a <= 'h6F)) return 8'hFF;
        case (a)
            'h05: return 8'h01;  'h0D: return 8'hF8;  'h40: return 8'hF1;
            'h42: return 8'hF7;  'h49: return 8'h73;  'h57: return 8'h60;
            'h58: return 8'h86;  'h5B: return 8'h4F;  'h5D: return 8'h53;
            'h5F: return 8'h7F;  'h72: return 8'h0F;  'h74: return 8'h2B;
            'h80: return 8'h84;  'h81: return 8'h81;  'h83: return 8'h10;
            default: begin ok = 1'b0; return 8'h00; end
        endcase
    endfunction

    function automatic logic [7:0] exp_write(input int a, input logic [7:0] d);
        bit ok;
        logic [7:0] m;
        m = exp_mask(a, ok);
        if (ok) return d & m;                               // R3, R4
        if (a == 'h41) return (d & 8'hD6) | 8'h08;          // R5
        if (a == 'h07) return model[a] & ~(d & 8'hF8);      // R6
        if (a >= 'h2C && a <= 'h2F)                         // R7
            return model['h70][3] ? d : model[a];
        return model[a];                                    // R8
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag_for(input int a);
        bit ok;
        logic [7:0] m;
        m = exp_mask(a, ok);
        if (ok) return (m == 8'hFF) ? "R3" : "R4";
        if (a == 'h41) return "R5";
        if (a == 'h07) return "R6";
        if (a >= 'h2C && a <= 'h2F) return "R7";
        return "R8";
    endfunction

    task automatic check_exports();
        check("R9 ext_cache_en", ext_cache_en, model['h42][0]);
        check("R9 int_cache_en", int_cache_en, model['h43][0]);
        check("R10 mem_route", mem_route, model['h47]);
        check("R10 smram_ctl", smram_ctl, model['h48]);
        check("R10 shadow_rd_en", shadow_rd_en, {model['h4D], model['h4C]});
        check("R10 shadow_wr_en", shadow_wr_en, {model['h4F], model['h4E]});
    endtask

    // write with a same-cycle read, then read back after the edge
    task automatic wr(input int a, input logic [7:0] d);
        logic [7:0] e;
        @(negedge clk);
        cfg_addr = 8'(a); cfg_wdata = d; cfg_we = 1'b1;
        #1;
        check("R2 pre-write read", cfg_rdata, model[a]);
        e = exp_write(a, d);
        @(negedge clk);
        cfg_we = 1'b0;
        model[a] = e;
        #1;
        check(tag_for(a), {a[7:0], cfg_rdata}, {a[7:0], e});
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < 256; a++) model[a] = exp_reset(a);

        // R1: every byte after reset
        for (int a = 0; a < 256; a++) begin
            cfg_addr = 8'(a);
            #1;
            check("R1 reset", {a[7:0], cfg_rdata}, {a[7:0], exp_reset(a)});
        end
        check_exports();

        // walk FFh then 00h through every offset (2Ch..2Fh locked here: 70h=22h)
        for (int a = 0; a < 256; a++) begin
            wr(a, 8'hFF);
            wr(a, 8'h00);
        end
        check_exports();

        // R5 directed: forced bit even with zero data
        wr('h41, 8'h00);
        check("R5 forced bit", cfg_rdata[3], 1'b1);

        // R7 directed: unlock, write, relock, write again
        wr('h70, 8'h08);
        wr('h2C, 8'hAB);
        check("R7 unlocked write", cfg_rdata, 8'hAB);
        wr('h70, 8'h00);
        wr('h2C, 8'h55);
        check("R7 locked write dropped", cfg_rdata, 8'hAB);

        // R9/R10 directed
        wr('h42, 8'h01);
        wr('h43, 8'h01);
        wr('h4C, 8'h5A);
        wr('h4D, 8'hC3);
        check_exports();
        wr('h42, 8'h00);
        check_exports();

        // random mix, biased toward interesting offsets
        for (int i = 0; i < N_RANDOM; i++) begin
            int a;
            logic [7:0] d;
            case ($urandom_range(0, 3))
                0: a = 'h2C + $urandom_range(0, 3);
                1: a = 'h70;
                2: a = 'h40 + $urandom_range(0, 'h47);
                default: a = $urandom_range(0, 255);
            endcase
            d = 8'($urandom);
            wr(a, d);
            if (i % 64 == 0) check_exports();
        end

        // final sweep of all bytes against the model
        @(negedge clk);
        for (int a = 0; a < 256; a++) begin
            cfg_addr = 8'(a);
            #1;
            check("R2 final sweep", {a[7:0], cfg_rdata}, {a[7:0], model[a]});
        end
        check_exports();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule